// File: doc/BRIEF.md
# Serial Converter Read Controller

This block is the host-side master for a three-wire successive-approximation converter that sends its result serially. It divides a fast system clock down to a slow data clock and pulls chip-select low when a start request arrives. It then runs one conversion frame. The first two data-clock periods belong to the converter's input sampling, and the third period carries a single low null bit. The controller passes over all three and shifts in the N-bit result, most significant bit first. It samples the data line on rising data-clock edges, because the converter changes the line on falling edges.

When the frame ends, the controller raises chip-select, which puts the converter into full shutdown. In the same cycle it presents the word with a one-cycle valid pulse. A repeat mode restarts conversions at a fixed sample period. Between frames, chip-select stays high for the remainder of each period, so the converter spends as much time as possible shut down. Resolution (8, 10 or 12 bits), divider, sample period, input synchroniser depth and the null-bit check are parameters. Elaboration rejects settings that break the converter's clock limits: 400 ns minimum per phase and 10 kHz minimum rate.

Top module: `sar_adc_reader`

## Requirements
- R1: During and after reset, with no start request, chip-select is high, the data clock is low and the valid and error outputs are low.
- R2: A start request sampled while idle drives chip-select low on that same clock edge, with the data clock low. The first rising data-clock edge follows HALF_DIV system cycles later.
- R3: While chip-select is low, each data-clock high phase and low phase lasts exactly HALF_DIV system cycles. Elaboration rejects a HALF_DIV below the 400 ns phase minimum, and a full period longer than 100 us.
- R4: A frame lasts exactly RES_BITS+4 data-clock periods, which is 2*HALF_DIV*(RES_BITS+4) system cycles. Chip-select rises together with the final falling data-clock edge.
- R5: The result holds the bits sampled on rising edges 4 through RES_BITS+3 of the frame. The first is the MSB, at res_data[RES_BITS-1]. The bits on rising edges 1 and 2 (sampling) and on edge 3 (null slot) never enter the result.
- R6: res_valid pulses high for exactly one system cycle, on the edge where chip-select rises. res_data holds the captured word until the next frame ends.
- R7: A start request that arrives while a frame is running is ignored. Once that frame ends without repeat mode, no further frame starts.
- R8: With repeat_en high, chip-select falls once every 2*HALF_DIV*SAMPLE_DCLKS system cycles, and stays high for the 2*HALF_DIV*(SAMPLE_DCLKS-RES_BITS-4) cycles between frames. A start request during that gap is ignored. Repeat stops when repeat_en is low at a frame end or at a gap end.
- R9: With NULL_CHECK set, null_err pulses together with res_valid when the bit sampled in the null slot (rising edge 3) was high, and stays low otherwise.
- R10: The data clock is low whenever chip-select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, sampled while idle |
| repeat_en | input | 1 | Keep converting at the fixed sample period |
| adc_dout | input | 1 | Serial data from the converter |
| adc_sclk | output | 1 | Data clock to the converter |
| adc_cs_n | output | 1 | Active-low chip-select; high means shutdown |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| res_data | output | RES_BITS | Captured conversion word, MSB in the top bit |
| null_err | output | 1 | Null slot carried a high bit (pulses with res_valid) |

## Verification
Chip-select is due low one system cycle after the cycle that presents start. The first data-clock rise is due HALF_DIV cycles after that, and each high phase lasts HALF_DIV cycles. The result and its valid pulse are due exactly 2*HALF_DIV*(RES_BITS+4) cycles after chip-select falls, and in repeat mode the next fall is due 2*HALF_DIV*(SAMPLE_DCLKS-RES_BITS-4) cycles after the result. The bench counts falling system-clock edges from each stimulus and compares the count at which an output changes against these figures. Every port is therefore read half a cycle after the edge that updates it. The converter model changes its data line half a system cycle after each falling data-clock edge, drives ones during the sampling periods so that any leak into the result shows, and follows the last result bit with zeros.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

   // Sequencer states
   typedef enum logic [1:0] {
      RD_IDLE  = 2'd0,
      RD_FRAME = 2'd1,
      RD_GAP   = 2'd2
   } rd_state_e;

   // Periods ahead of the MSB: two sampling periods plus the null slot
   localparam int LEAD_PERIODS = 3;

   // Whole frame in data-clock periods: lead-in, result bits, closing period
   function automatic int frame_len(input int bits);
      return bits + LEAD_PERIODS + 1;
   endfunction

   // Fewest system cycles that cover a 400 ns clock phase
   function automatic int min_half_cycles(input int sys_khz);
      return (sys_khz + 2499) / 2500;
   endfunction

   // Most system cycles allowed in one data-clock period (10 kHz floor)
   function automatic int max_period_cycles(input int sys_khz);
      return sys_khz / 10;
   endfunction

endpackage

// File: rtl/sar_rd_clkgen.sv
module sar_rd_clkgen #(
   parameter int HALF_DIV = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sclk,
   output logic rise_evt,
   output logic fall_evt
);

   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

   logic [CW-1:0] cnt;
   logic          wrap;

   assign wrap     = run && (cnt == LAST);
   assign rise_evt = wrap && !sclk;
   assign fall_evt = wrap && sclk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         sclk <= 1'b0;
      end else if (!run) begin
         cnt  <= '0;
         sclk <= 1'b0;
      end else if (wrap) begin
         cnt  <= '0;
         sclk <= ~sclk;
      end else begin
         cnt  <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/sar_rd_seq.sv
module sar_rd_seq
   import sar_rd_pkg::*;
#(
   parameter int FRAME   = 16,
   parameter int GAP_CYC = 160,
   parameter int PW      = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          repeat_en,
   input  logic          fall_evt,
   output logic          cs_n,
   output logic          run,
   output logic          frame_last,
   output logic [PW-1:0] period
);

   localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC + 1) : 1;
   localparam logic [PW-1:0] LAST_P  = PW'(FRAME - 1);
   localparam logic [GW-1:0] LAST_G  = GW'(GAP_CYC - 1);

   rd_state_e     state;
   logic [GW-1:0] gap_cnt;

   assign run        = (state == RD_FRAME);
   assign frame_last = run && fall_evt && (period == LAST_P);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= RD_IDLE;
         cs_n    <= 1'b1;
         period  <= '0;
         gap_cnt <= '0;
      end else begin
         case (state)
            RD_IDLE: begin
               if (start) begin
                  state  <= RD_FRAME;
                  cs_n   <= 1'b0;
                  period <= '0;
               end
            end
            RD_FRAME: begin
               if (frame_last) begin
                  cs_n    <= 1'b1;
                  period  <= '0;
                  gap_cnt <= '0;
                  state   <= repeat_en ? RD_GAP : RD_IDLE;
               end else if (fall_evt) begin
                  period <= period + 1'b1;
               end
            end
            RD_GAP: begin
               if (gap_cnt == LAST_G) begin
                  gap_cnt <= '0;
                  if (repeat_en) begin
                     state <= RD_FRAME;
                     cs_n  <= 1'b0;
                  end else begin
                     state <= RD_IDLE;
                  end
               end else begin
                  gap_cnt <= gap_cnt + 1'b1;
               end
            end
            default: begin
               state <= RD_IDLE;
               cs_n  <= 1'b1;
            end
         endcase
      end
   end

endmodule

// File: rtl/sar_rd_capture.sv
module sar_rd_capture
   import sar_rd_pkg::*;
#(
   parameter int RES_BITS    = 12,
   parameter int PW          = 5,
   parameter int SYNC_STAGES = 2,
   parameter bit NULL_CHECK  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sdi_raw,
   input  logic                rise_evt,
   input  logic                frame_last,
   input  logic [PW-1:0]       period,
   output logic [RES_BITS-1:0] res_data,
   output logic                res_valid,
   output logic                null_err
);

   localparam logic [PW-1:0] NULL_P  = PW'(LEAD_PERIODS - 1);
   localparam logic [PW-1:0] FIRST_P = PW'(LEAD_PERIODS);
   localparam logic [PW-1:0] LAST_P  = PW'(LEAD_PERIODS + RES_BITS - 1);

   logic                sdi;
   logic [RES_BITS-1:0] shreg;
   logic                in_data;
   logic                in_null;

   // Optional resynchronisation of the serial input
   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign sdi = sdi_raw;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sq;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sq <= '0;
            else        sq <= (sq << 1) | SYNC_STAGES'(sdi_raw);
         end
         assign sdi = sq[SYNC_STAGES-1];
      end
   endgenerate

   assign in_data = rise_evt && (period >= FIRST_P) && (period <= LAST_P);
   assign in_null = rise_evt && (period == NULL_P);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg     <= '0;
         res_data  <= '0;
         res_valid <= 1'b0;
      end else begin
         if (in_data) shreg <= {shreg[RES_BITS-2:0], sdi};
         res_valid <= frame_last;
         if (frame_last) res_data <= shreg;
      end
   end

   generate
      if (NULL_CHECK) begin : g_nullchk
         logic null_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               null_q   <= 1'b0;
               null_err <= 1'b0;
            end else begin
               if (in_null) null_q <= sdi;
               null_err <= frame_last && null_q;
            end
         end
      end else begin : g_nonull
         assign null_err = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/sar_adc_reader.sv
module sar_adc_reader
   import sar_rd_pkg::*;
#(
   parameter int RES_BITS     = 12,
   parameter int SYS_CLK_KHZ  = 50000,
   parameter int HALF_DIV     = 20,
   parameter int SAMPLE_DCLKS = 20,
   parameter int SYNC_STAGES  = 2,
   parameter bit NULL_CHECK   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                repeat_en,
   input  logic                adc_dout,
   output logic                adc_sclk,
   output logic                adc_cs_n,
   output logic                res_valid,
   output logic [RES_BITS-1:0] res_data,
   output logic                null_err
);

   localparam int FRAME   = frame_len(RES_BITS);
   localparam int PW      = $clog2(FRAME + 1);
   localparam int GAP_CYC = (SAMPLE_DCLKS - FRAME) * 2 * HALF_DIV;

   // Elaboration-time guards on the parameter set
   generate
      if (!(RES_BITS == 8 || RES_BITS == 10 || RES_BITS == 12)) begin : g_bad_res
         $error("RES_BITS must be 8, 10 or 12");
      end
      if (HALF_DIV < min_half_cycles(SYS_CLK_KHZ)) begin : g_bad_fast
         $error("HALF_DIV gives a data-clock phase under 400 ns");
      end
      if (2 * HALF_DIV > max_period_cycles(SYS_CLK_KHZ)) begin : g_bad_slow
         $error("HALF_DIV gives a data clock under 10 kHz");
      end
      if (SAMPLE_DCLKS <= FRAME) begin : g_bad_rate
         $error("SAMPLE_DCLKS must exceed the frame length");
      end
      if (HALF_DIV <= SYNC_STAGES + 1) begin : g_bad_sync
         $error("HALF_DIV too short for the input synchroniser");
      end
   endgenerate

   logic          run;
   logic          rise_evt;
   logic          fall_evt;
   logic          frame_last;
   logic [PW-1:0] period;

   sar_rd_clkgen #(
      .HALF_DIV (HALF_DIV)
   ) u_clkgen (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .sclk     (adc_sclk),
      .rise_evt (rise_evt),
      .fall_evt (fall_evt)
   );

   sar_rd_seq #(
      .FRAME   (FRAME),
      .GAP_CYC (GAP_CYC),
      .PW      (PW)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .repeat_en  (repeat_en),
      .fall_evt   (fall_evt),
      .cs_n       (adc_cs_n),
      .run        (run),
      .frame_last (frame_last),
      .period     (period)
   );

   sar_rd_capture #(
      .RES_BITS    (RES_BITS),
      .PW          (PW),
      .SYNC_STAGES (SYNC_STAGES),
      .NULL_CHECK  (NULL_CHECK)
   ) u_capture (
      .clk        (clk),
      .rst_n      (rst_n),
      .sdi_raw    (adc_dout),
      .rise_evt   (rise_evt),
      .frame_last (frame_last),
      .period     (period),
      .res_data   (res_data),
      .res_valid  (res_valid),
      .null_err   (null_err)
   );

endmodule

// File: rtl/sar_adc_reader_chk.sv
module sar_adc_reader_chk #(
   parameter int FRAME_LEN = 16,
   parameter int HALF_DIV  = 20
) (
   input logic clk,
   input logic rst_n,
   input logic adc_sclk,
   input logic adc_cs_n,
   input logic res_valid,
   input logic null_err
);

   localparam int RW = $clog2(HALF_DIV + 1) + 1;
   localparam int FW = $clog2(FRAME_LEN + 2);

   logic          sclk_q;
   logic [RW-1:0] run_len;
   logic [FW-1:0] rise_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q   <= 1'b0;
         run_len  <= '0;
         rise_cnt <= '0;
      end else begin
         sclk_q <= adc_sclk;
         if (adc_sclk != sclk_q)  run_len <= RW'(1);
         else if (run_len != '1)  run_len <= run_len + 1'b1;
         if (adc_cs_n)                   rise_cnt <= '0;
         else if (adc_sclk && !sclk_q)   rise_cnt <= rise_cnt + 1'b1;
      end
   end

   assert_cs_fall_clk_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_cs_n) |-> !adc_sclk);

   assert_high_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!adc_sclk && sclk_q) |-> (run_len == RW'(HALF_DIV)));

   assert_frame_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_cs_n) |-> (rise_cnt == FW'(FRAME_LEN)));

   assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   assert_valid_at_cs_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $rose(adc_cs_n));

   assert_null_err_with_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      null_err |-> res_valid);

   assert_sclk_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      adc_cs_n |-> !adc_sclk);

endmodule

bind sar_adc_reader sar_adc_reader_chk #(
   .FRAME_LEN (RES_BITS + 4),
   .HALF_DIV  (HALF_DIV)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .adc_sclk  (adc_sclk),
   .adc_cs_n  (adc_cs_n),
   .res_valid (res_valid),
   .null_err  (null_err)
);

// File: tb/sar_adc_reader_bench.sv
module sar_adc_reader_bench;

   localparam int N      = 12;
   localparam int H      = 20;
   localparam int SAMPLE = 20;
   localparam int F      = N + 4;
   localparam int FRAME_CYC  = 2 * H * F;
   localparam int PERIOD_CYC = 2 * H * SAMPLE;
   localparam int GAP        = PERIOD_CYC - FRAME_CYC;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         repeat_en = 1'b0;
   logic         adc_dout = 1'b1;
   logic         adc_sclk;
   logic         adc_cs_n;
   logic         res_valid;
   logic [N-1:0] res_data;
   logic         null_err;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   sar_adc_reader #(
      .RES_BITS     (N),
      .SYS_CLK_KHZ  (50000),
      .HALF_DIV     (H),
      .SAMPLE_DCLKS (SAMPLE),
      .SYNC_STAGES  (2),
      .NULL_CHECK   (1'b1)
   ) u_sar_adc_reader (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .repeat_en (repeat_en),
      .adc_dout  (adc_dout),
      .adc_sclk  (adc_sclk),
      .adc_cs_n  (adc_cs_n),
      .res_valid (res_valid),
      .res_data  (res_data),
      .null_err  (null_err)
   );

   // Converter model
   logic [N-1:0] model_word = '0;
   logic         model_null = 1'b0;
   logic [N-1:0] cur_word = '0;
   logic         cur_null = 1'b0;
   int           fcnt = 0;
   logic         prev_cs = 1'b1;

   always @(negedge adc_cs_n or posedge adc_cs_n or negedge adc_sclk) begin
      if (adc_cs_n) begin
         prev_cs = 1'b1;
      end else if (prev_cs) begin
         prev_cs  = 1'b0;
         fcnt     = 0;
         cur_word = model_word;
         cur_null = model_null;
      end else begin
         fcnt = fcnt + 1;
      end
   end

   always @(negedge clk) begin
      if (adc_cs_n || fcnt < 2)   adc_dout = 1'b1;
      else if (fcnt == 2)         adc_dout = cur_null;
      else if (fcnt <= N + 2)     adc_dout = cur_word[N - 1 - (fcnt - 3)];
      else                        adc_dout = 1'b0;
   end

   // Rising data-clock edges within the current frame
   int rise_cnt = 0;
   always @(posedge adc_sclk or negedge adc_cs_n) begin
      if (adc_sclk) rise_cnt = rise_cnt + 1;
      else          rise_cnt = 0;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic t_reset();
      chk(adc_cs_n == 1'b1, "R1 cs_n in reset", int'(adc_cs_n), 1);
      chk(adc_sclk == 1'b0, "R1 sclk in reset", int'(adc_sclk), 0);
      @(negedge clk) rst_n = 1'b1;
      repeat (10) @(negedge clk);
      chk(adc_cs_n == 1'b1 && adc_sclk == 1'b0, "R1 idle after reset",
          int'({adc_cs_n, adc_sclk}), 2);
      chk(res_valid == 1'b0 && null_err == 1'b0, "R1 outputs low",
          int'({res_valid, null_err}), 0);
   endtask

   // One single-shot frame; optionally a second start arrives mid-frame
   task automatic t_frame(input logic [N-1:0] word, input logic nullv, input bit mid_start);
      int k;
      int j;
      int t;
      model_word = word;
      model_null = nullv;
      pulse_start();
      chk(adc_cs_n == 1'b0 && adc_sclk == 1'b0, "R2 cs low with sclk low",
          int'({adc_cs_n, adc_sclk}), 0);
      k = 0;
      while (!adc_sclk && k < 1000) begin @(negedge clk); k++; end
      chk(k == H, "R2 first rise delay", k, H);
      j = 0;
      while (adc_sclk && j < 1000) begin @(negedge clk); j++; end
      chk(j == H, "R3 high phase", j, H);
      t = k + j;
      while (!res_valid && t < 5000) begin
         @(negedge clk);
         t++;
         if (mid_start) start = (t == 100);
      end
      start = 1'b0;
      chk(t == FRAME_CYC, "R4 frame length", t, FRAME_CYC);
      chk(rise_cnt == F, "R4 rising edges", rise_cnt, F);
      chk(adc_cs_n == 1'b1, "R6 cs high with valid", int'(adc_cs_n), 1);
      chk(res_data == word, "R5 result word", int'(res_data), int'(word));
      chk(null_err == nullv, "R9 null error flag", int'(null_err), int'(nullv));
      @(negedge clk);
      chk(res_valid == 1'b0 && null_err == 1'b0, "R6 valid one cycle",
          int'({res_valid, null_err}), 0);
   endtask

   // Stray start during a frame, then a quiet window
   task automatic t_ignore();
      int lowc;
      int bad_sclk;
      t_frame(12'h9A3, 1'b0, 1'b1);
      lowc = 0;
      bad_sclk = 0;
      repeat (3 * PERIOD_CYC) begin
         @(negedge clk);
         if (!adc_cs_n) lowc++;
         if (adc_cs_n && adc_sclk) bad_sclk++;
      end
      chk(lowc == 0, "R7 no frame after stray start", lowc, 0);
      chk(bad_sclk == 0, "R10 sclk low while deselected", bad_sclk, 0);
      chk(res_data == 12'h9A3, "R6 result held", int'(res_data), 'h9A3);
   endtask

   // Back-to-back conversions at the fixed sample period
   task automatic t_repeat();
      logic [N-1:0] words [3];
      int t;
      int g;
      int lowc;
      words[0] = 12'h3C5;
      words[1] = 12'h000;
      words[2] = 12'hFFF;
      model_word = words[0];
      model_null = 1'b0;
      repeat_en = 1'b1;
      pulse_start();
      for (int i = 0; i < 3; i++) begin
         t = 0;
         while (!res_valid && t < 5000) begin
            @(negedge clk);
            t++;
            if (i == 2 && t == 50) repeat_en = 1'b0;
         end
         chk(t == FRAME_CYC, "R8 repeat frame length", t, FRAME_CYC);
         chk(res_data == words[i], "R5 repeat result", int'(res_data), int'(words[i]));
         if (i < 2) begin
            model_word = words[i + 1];
            g = 0;
            while (adc_cs_n && g < 5000) begin
               @(negedge clk);
               g++;
               if (i == 1) start = (g == 5);
            end
            start = 1'b0;
            chk(g == GAP, "R8 shutdown gap", g, GAP);
            chk(t + g == PERIOD_CYC, "R8 sample period", t + g, PERIOD_CYC);
         end else begin
            lowc = 0;
            repeat (2 * PERIOD_CYC) begin
               @(negedge clk);
               if (!adc_cs_n) lowc++;
            end
            chk(lowc == 0, "R8 repeat stops", lowc, 0);
         end
      end
   endtask

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      t_frame(12'hA5C, 1'b0, 1'b0);
      t_frame(12'h000, 1'b0, 1'b0);
      t_frame(12'hFFF, 1'b0, 1'b0);
      t_frame(12'h800, 1'b0, 1'b0);
      t_frame(12'h7FF, 1'b0, 1'b0);
      t_frame(12'h155, 1'b1, 1'b0);
      t_ignore();
      t_repeat();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule